// File: doc/BRIEF.md
# Special-Write Control Register File

A bank of 32-bit control registers behind a simple write port (address, data, strobe) and a combinational read port. Most words in the address space are ordinary storage. A handful carry their own write rule: the written data can clear bits, toggle bits, set bits, update a single bit, force the word to zero, mirror bits into a neighbouring status word, or fire a one-cycle reset pulse toward a graphics path.

An interrupt status word gathers event bits from a raise input and is cleared by software writing ones. An interrupt mask word is changed by toggling. The block drives an interrupt line from the two. A memory-controller command word drops its busy bit on every write. Under one command encoding, a write to it also wipes a stored device-ID word, but only while a repeater-control word allows it. Addresses below are word indices on `wr_addr`/`rd_addr`, and every register resets to zero except where stated.

Top module: `ctrl_regfile`

## Requirements
- R1: Word 0 (interrupt status) is write-1-to-clear: each data bit at 1 clears that status bit. Each `irq_raise[i]` high at a clock edge sets status bit i, and a raise wins over a clear in the same cycle.
- R2: A write to word 1 (interrupt mask) XORs data bits [15:0] into the mask. Mask bits [31:16] stay 0.
- R3: `irq` is high exactly while (status & mask) is nonzero, and it follows the register state from the edge that changed it.
- R4: Word 2 (graphics control) keeps only data bit 3. Every other bit reads back 0. `pause_en` equals the stored bit 3.
- R5: A write to word 2 with data bit 0 set drives `gfx_rst` high for exactly the one cycle after the write edge. A write with bit 0 clear gives no pulse.
- R6: A write to word 3 (mode) stores the full data. It also copies data bits 0 and 2 into bits 0 and 2 of word 4 (graphics status) and leaves the other bits of word 4 unchanged.
- R7: A write to word 5 ORs the data into it.
- R8: Word 6 resets to 0xFFFFFFFF. A write to it clears each bit that is 1 in the data.
- R9: A write to word 7 updates only bit 8, from data bit 8. All other bits stay 0.
- R10: Word 8 becomes 0 on any write, whatever the data.
- R11: A write to word 9 (memory command) stores the data with bit 31 forced to 0.
- R12: A write to word 9 clears word 10 (device ID) to 0 when data[27:16] = 0x021, data[9:6] = 1 and bit 7 of word 11 (repeater control) is 0. In every other case word 10 keeps its value.
- R13: All other words, including 4, 10 and 11, store the written data with no error. After reset every word reads 0 except word 6, and `irq`, `gfx_rst` and `pause_en` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 6 | Write word index |
| wr_data | input | 32 | Write data |
| irq_raise | input | 16 | Event bits that set interrupt status |
| rd_addr | input | 6 | Read word index |
| rd_data | output | 32 | Contents of the word at rd_addr |
| irq | output | 1 | Interrupt pending |
| gfx_rst | output | 1 | One-cycle graphics-path reset pulse |
| pause_en | output | 1 | Pause-enable flag from control bit 3 |

## Verification
A wrong write rule leaves a wrong word in storage, and it is visible on `rd_data` in the cycle right after the write edge. The bench therefore reads back each special word straight after each write. Damage to the status or mask words also shows at once on `irq`, so the bench compares the line against the expected (status & mask) after every step of raise, clear and toggle. Device-ID corruption stays hidden until the next read of word 10. For that reason each command encoding, including the near-misses on each of the three conditions, is followed by a read of that word.

// File: rtl/ctrl_regfile.sv
module ctrl_regfile #(
  parameter int ADDR_W = 6,
  parameter int IRQ_W  = 16,
  parameter logic [ADDR_W-1:0] A_ISTAT  = 6'd0,
  parameter logic [ADDR_W-1:0] A_IMASK  = 6'd1,
  parameter logic [ADDR_W-1:0] A_GCTRL  = 6'd2,
  parameter logic [ADDR_W-1:0] A_GMODE  = 6'd3,
  parameter logic [ADDR_W-1:0] A_GSTAT  = 6'd4,
  parameter logic [ADDR_W-1:0] A_ORBOX  = 6'd5,
  parameter logic [ADDR_W-1:0] A_ANDBOX = 6'd6,
  parameter logic [ADDR_W-1:0] A_BIT8   = 6'd7,
  parameter logic [ADDR_W-1:0] A_ZERO   = 6'd8,
  parameter logic [ADDR_W-1:0] A_CMD    = 6'd9,
  parameter logic [ADDR_W-1:0] A_DEVID  = 6'd10,
  parameter logic [ADDR_W-1:0] A_RPT    = 6'd11,
  parameter logic [31:0] ANDBOX_RST     = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [IRQ_W-1:0]  irq_raise,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic              irq,
  output logic              gfx_rst,
  output logic              pause_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD   = 32 - IRQ_W;

  logic [31:0] regs [DEPTH];
  logic [31:0] wr_next, istat_next, gstat_next, clr_mask;
  logic        hit_mode, devid_clr;

  assign clr_mask   = (wr_en && wr_addr == A_ISTAT) ? wr_data : 32'h0;
  assign istat_next = (regs[A_ISTAT] & ~clr_mask) | {{PAD{1'b0}}, irq_raise};
  assign hit_mode   = wr_en && wr_addr == A_GMODE;
  assign gstat_next = {regs[A_GSTAT][31:3], wr_data[2], regs[A_GSTAT][1], wr_data[0]};
  assign devid_clr  = wr_en && wr_addr == A_CMD && wr_data[27:16] == 12'h021
                      && wr_data[9:6] == 4'd1 && !regs[A_RPT][7];

  always_comb begin
    wr_next = wr_data;
    case (wr_addr)
      A_IMASK:  wr_next = regs[A_IMASK] ^ {{PAD{1'b0}}, wr_data[IRQ_W-1:0]};
      A_GCTRL:  wr_next = {28'h0, wr_data[3], 3'b000};
      A_ORBOX:  wr_next = regs[A_ORBOX] | wr_data;
      A_ANDBOX: wr_next = regs[A_ANDBOX] & ~wr_data;
      A_BIT8:   wr_next = {regs[A_BIT8][31:9], wr_data[8], regs[A_BIT8][7:0]};
      A_ZERO:   wr_next = 32'h0;
      A_CMD:    wr_next = {1'b0, wr_data[30:0]};
      default:  wr_next = wr_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++)
        regs[i] <= (i == int'(A_ANDBOX)) ? ANDBOX_RST : 32'h0;
      gfx_rst <= 1'b0;
    end else begin
      gfx_rst <= wr_en && wr_addr == A_GCTRL && wr_data[0];
      if (wr_en && wr_addr != A_ISTAT) regs[wr_addr] <= wr_next;
      regs[A_ISTAT] <= istat_next;
      if (hit_mode)  regs[A_GSTAT] <= gstat_next;
      if (devid_clr) regs[A_DEVID] <= 32'h0;
    end
  end

  assign rd_data  = regs[rd_addr];
  assign irq      = |(regs[A_ISTAT][IRQ_W-1:0] & regs[A_IMASK][IRQ_W-1:0]);
  assign pause_en = regs[A_GCTRL][3];

  p_w1c_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ISTAT && irq_raise == '0) |=> ((regs[A_ISTAT] & $past(wr_data)) == 32'h0));

  p_raise_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((regs[A_ISTAT][IRQ_W-1:0] & $past(irq_raise)) == $past(irq_raise)));

  p_mask_xor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_IMASK) |=> regs[A_IMASK][IRQ_W-1:0] == $past(regs[A_IMASK][IRQ_W-1:0] ^ wr_data[IRQ_W-1:0]));

  p_pulse_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gfx_rst |-> $past(wr_en && wr_addr == A_GCTRL && wr_data[0]));

  p_mode_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hit_mode |=> (regs[A_GSTAT][0] == $past(wr_data[0]) && regs[A_GSTAT][2] == $past(wr_data[2])
                  && regs[A_GSTAT][1] == $past(regs[A_GSTAT][1])));

  p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ZERO) |=> regs[A_ZERO] == 32'h0);

  p_busy_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !regs[A_CMD][31]);

  p_devid_clr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    devid_clr |=> regs[A_DEVID] == 32'h0);
endmodule

// File: tb/tb_ctrl_regfile.sv
module tb_ctrl_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [15:0] irq_raise = '0;
  logic [5:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        irq, gfx_rst, pause_en;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ctrl_regfile dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .irq_raise(irq_raise), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .gfx_rst(gfx_rst), .pause_en(pause_en)
  );

  typedef struct packed {
    logic [5:0]  a;
    logic [31:0] d;
    logic [5:0]  ra;
    logic [31:0] e;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{6'd2,  32'hFFFF_FFFF, 6'd2,  32'h0000_0008},  // R4
    '{6'd2,  32'h0000_0001, 6'd2,  32'h0000_0000},  // R4
    '{6'd3,  32'h1234_5675, 6'd3,  32'h1234_5675},  // R6
    '{6'd3,  32'h1234_5675, 6'd4,  32'h0000_0005},  // R6
    '{6'd4,  32'h0000_00F0, 6'd4,  32'h0000_00F0},  // R13
    '{6'd3,  32'h0000_0001, 6'd4,  32'h0000_00F1},  // R6
    '{6'd3,  32'h0000_0004, 6'd4,  32'h0000_00F4},  // R6
    '{6'd5,  32'h0000_00FF, 6'd5,  32'h0000_00FF},  // R7
    '{6'd5,  32'h0000_0F00, 6'd5,  32'h0000_0FFF},  // R7
    '{6'd6,  32'h0000_FFFF, 6'd6,  32'hFFFF_0000},  // R8
    '{6'd6,  32'hF000_0000, 6'd6,  32'h0FFF_0000},  // R8
    '{6'd7,  32'h0000_0100, 6'd7,  32'h0000_0100},  // R9
    '{6'd7,  32'hFFFF_FEFF, 6'd7,  32'h0000_0000},  // R9
    '{6'd8,  32'h1234_5678, 6'd8,  32'h0000_0000},  // R10
    '{6'd9,  32'hFFFF_FFFF, 6'd9,  32'h7FFF_FFFF},  // R11
    '{6'd20, 32'hDEAD_BEEF, 6'd20, 32'hDEAD_BEEF},  // R13
    '{6'd63, 32'h0000_0001, 6'd63, 32'h0000_0001},  // R13
    '{6'd1,  32'h0001_00F0, 6'd1,  32'h0000_00F0},  // R2
    '{6'd1,  32'h0000_00FF, 6'd1,  32'h0000_000F}   // R2
  };

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [15:0] r = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; irq_raise = r;
    @(negedge clk);
    wr_en = 1'b0; irq_raise = '0;
  endtask

  task automatic raise(input logic [15:0] r);
    @(negedge clk);
    irq_raise = r;
    @(negedge clk);
    irq_raise = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] v);
    rd_addr = a;
    #0.1;
    v = rd_data;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(6'd0, v);  check("R13 reset status", v, 32'h0);
    rd(6'd6, v);  check("R13 reset and-box", v, 32'hFFFF_FFFF);
    rd(6'd20, v); check("R13 reset plain", v, 32'h0);
    check("R13 reset irq", {31'h0, irq}, 32'h0);
    check("R13 reset gfx_rst", {31'h0, gfx_rst}, 32'h0);
    check("R13 reset pause_en", {31'h0, pause_en}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(TBL[i].a, TBL[i].d);
      rd(TBL[i].ra, v);
      check($sformatf("table row %0d", i), v, TBL[i].e);
    end

    // R4 pause flag
    wr(6'd2, 32'h0000_0008);
    check("R4 pause_en set", {31'h0, pause_en}, 32'h1);
    wr(6'd2, 32'h0000_0000);
    check("R4 pause_en clear", {31'h0, pause_en}, 32'h0);

    // R5 pulse width
    wr(6'd2, 32'h0000_0009);
    check("R5 pulse high", {31'h0, gfx_rst}, 32'h1);
    @(negedge clk);
    check("R5 pulse one cycle", {31'h0, gfx_rst}, 32'h0);
    wr(6'd2, 32'h0000_0008);
    check("R5 no pulse bit0 clear", {31'h0, gfx_rst}, 32'h0);

    // R1/R3 interrupt path, mask is 0x000F
    raise(16'h0010);
    rd(6'd0, v); check("R1 raise sets", v, 32'h10);
    check("R3 masked off", {31'h0, irq}, 32'h0);
    raise(16'h0001);
    check("R3 irq high", {31'h0, irq}, 32'h1);
    wr(6'd0, 32'h0000_0010);
    rd(6'd0, v); check("R1 w1c partial", v, 32'h1);
    check("R3 irq stays", {31'h0, irq}, 32'h1);
    wr(6'd0, 32'h0000_0001);
    rd(6'd0, v); check("R1 w1c all", v, 32'h0);
    check("R3 irq drops", {31'h0, irq}, 32'h0);
    wr(6'd0, 32'h0000_0004, 16'h0004);
    rd(6'd0, v); check("R1 raise wins", v, 32'h4);
    check("R3 irq on bit2", {31'h0, irq}, 32'h1);
    wr(6'd1, 32'h0000_0004);
    rd(6'd1, v); check("R2 toggle off", v, 32'hB);
    check("R3 irq after mask toggle", {31'h0, irq}, 32'h0);

    // R12 device-ID clear conditions
    wr(6'd10, 32'h0000_ABCD);
    wr(6'd11, 32'h0000_0080);
    wr(6'd9, 32'h0021_0040);
    rd(6'd10, v); check("R12 blocked by repeater bit", v, 32'hABCD);
    wr(6'd11, 32'h0000_0000);
    wr(6'd9, 32'h0021_0040);
    rd(6'd10, v); check("R12 cleared", v, 32'h0);
    wr(6'd10, 32'h0000_0055);
    wr(6'd9, 32'h0021_0080);
    rd(6'd10, v); check("R12 wrong op field", v, 32'h55);
    wr(6'd9, 32'h0022_0040);
    rd(6'd10, v); check("R12 wrong address field", v, 32'h55);
    rd(6'd9, v);  check("R11 cmd stored", v, 32'h0022_0040);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule